// File: doc/BRIEF.md
# Gated Binary-to-One-Cold Decoder

This block turns a small binary address into a group of active-low select lines. When the block is enabled, exactly one line is driven to 0, and that line is the one whose index equals the address. Every other line stays at 1. Its main use is address decoding, where each low output picks one device or region out of several.

The decoder is qualified by a gate input vector. In the default 3-to-8 form, the gate vector has three bits. Bit 0 is active-high, and bits 1 and 2 are active-low. The decoder is enabled only when all three gate bits are in their active state. Setting `ADDR_W` to 2 gives a 2-to-4 form instead. In that form, the gate vector shrinks to a single active-low bit. The path from inputs to outputs is purely combinational: nothing is latched or registered.

Top module: `onecold_decoder`

## Requirements
- R1: While enabled, address value n drives `sel_no[n]` to 0, and every other bit of `sel_no` is 1. Bit n of the output corresponds to address value n.
- R2: In the 3-to-8 form (`ADDR_W`=3), the block is enabled only when `gate_i` equals 3'b001. That is, bit 0 is 1 while bits 1 and 2 are both 0.
- R3: While not enabled, every bit of `sel_no` is 1, for any address.
- R4: In the 2-to-4 form (`ADDR_W`=2), `gate_i` is one bit wide and active-low. With `gate_i`=0, address 2'b10 gives `sel_no`=4'b1011. With `gate_i`=1, the output is 4'b1111.
- R5: The output follows changes on `addr_i` and `gate_i` within the same time step, with no clock involved.
- R6: For every input combination, at most one bit of `sel_no` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | ADDR_W | Binary address to decode |
| gate_i | input | 3 (ADDR_W=3) or 1 (ADDR_W=2) | Enable gates: 3-to-8 form uses bit 0 active-high and bits 1, 2 active-low; 2-to-4 form uses one active-low bit |
| sel_no | output | 2**ADDR_W | Active-low one-cold select lines |

## Verification
The block holds no state, so any internal fault shows up at the ports in the same time step as the input that exposes it. A broken enable term would show as a low output under a disabled gate pattern, or as all-ones under the single enabling pattern. A broken address term would show as a wrong index going low, as two lines low at once, or as no line low. Sweeping every address under every gate pattern, in both forms, therefore exposes each such fault at the first vector that reaches it.

// File: rtl/onecold_dec_pkg.sv
`timescale 1ns/1ps
package onecold_dec_pkg;
  // gate vector width for a given address width
  function automatic int unsigned gate_w_for(int unsigned addr_w);
    return (addr_w == 3) ? 3 : 1;
  endfunction
endpackage

// File: rtl/dec_gate_qualify.sv
`timescale 1ns/1ps
module dec_gate_qualify #(
  parameter int unsigned GATE_W = 3
) (
  input  logic [GATE_W-1:0] gate_i,
  output logic              en_o
);
  generate
    if (GATE_W == 3) begin : g_three_gate
      // bit0 active-high, bits 1 and 2 active-low
      assign en_o = gate_i[0] & ~gate_i[1] & ~gate_i[2];
    end else begin : g_single_gate
      assign en_o = ~gate_i[0];
    end
  endgenerate
endmodule

// File: rtl/dec_onehot.sv
`timescale 1ns/1ps
module dec_onehot #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned OUT_N = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic [OUT_N-1:0]  hot_o
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_term
    assign hot_o[i] = en_i & (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/onecold_decoder.sv
`timescale 1ns/1ps
module onecold_decoder #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned GATE_W = onecold_dec_pkg::gate_w_for(ADDR_W),
  localparam int unsigned OUT_N  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [GATE_W-1:0] gate_i,
  output logic [OUT_N-1:0]  sel_no
);
  logic             en;
  logic [OUT_N-1:0] hot;

  dec_gate_qualify #(.GATE_W(GATE_W)) u_qualify (
    .gate_i(gate_i),
    .en_o  (en)
  );

  dec_onehot #(.ADDR_W(ADDR_W)) u_onehot (
    .addr_i(addr_i),
    .en_i  (en),
    .hot_o (hot)
  );

  assign sel_no = ~hot;

  always_comb begin
    p_at_most_one_low_r6: assert ($countones(~sel_no) <= 1)
      else $error("more than one select low");
    if (en) begin
      p_addr_line_low_r1: assert (sel_no[addr_i] == 1'b0)
        else $error("addressed line not low");
    end else begin
      p_idle_all_high_r3: assert (&sel_no)
        else $error("line low while disabled");
    end
    p_low_iff_enabled_r2: assert ((&sel_no) != en)
      else $error("enable and output disagree");
  end
endmodule

// File: tb/onecold_decoder_bench.sv
`timescale 1ns/1ps
module onecold_decoder_bench;
  logic clk = 1'b0;
  logic rst_ni;
  always #2.5 clk = ~clk;

  logic [2:0] a8, g8;
  logic [7:0] y8;
  logic [1:0] a4;
  logic [0:0] g4;
  logic [3:0] y4;

  int checks = 0;
  int failures = 0;

  onecold_decoder u_onecold_decoder (.addr_i(a8), .gate_i(g8), .sel_no(y8));
  onecold_decoder #(.ADDR_W(2)) u_onecold_decoder_w2 (.addr_i(a4), .gate_i(g4), .sel_no(y4));

  function automatic logic [7:0] model(int n, int addr, bit en);
    logic [7:0] r;
    r = '1;
    for (int k = 0; k < n; k++) if (en && k == addr) r[k] = 1'b0;
    return r;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_one_cold(string req, logic [7:0] act, int n);
    int lows;
    lows = 0;
    for (int k = 0; k < n; k++) if (act[k] == 1'b0) lows++;
    checks++;
    if (lows > 1) begin
      failures++;
      $display("FAIL %s actual=%0d lows expected<=1", req, lows);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    a8 = '0; g8 = 3'b110; a4 = '0; g4 = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R3 reset wide", y8, 8'hFF);
    check("R4 reset narrow", {4'hF, y4}, 8'hFF);
    rst_ni = 1'b1;

    // R1 R2 R3 R6: every address under every gate pattern
    for (int g = 0; g < 8; g++) begin
      for (int a = 0; a < 8; a++) begin
        bit en;
        @(negedge clk);
        g8 = 3'(g); a8 = 3'(a);
        en = (g == 1);
        #1;
        check(en ? "R1/R2 enabled" : "R2/R3 disabled", y8, model(8, a, en));
        check_one_cold("R6 wide", y8, 8);
      end
    end

    // R4: narrow form sweep
    for (int g = 0; g < 2; g++) begin
      for (int a = 0; a < 4; a++) begin
        @(negedge clk);
        g4 = 1'(g); a4 = 2'(a);
        #1;
        check("R4 narrow sweep", {4'hF, y4}, {4'hF, model(4, a, g == 0)[3:0]});
        check_one_cold("R6 narrow", {4'hF, y4}, 4);
      end
    end
    @(negedge clk);
    g4 = 1'b0; a4 = 2'b10;
    #1 check("R4 addr2", {4'hF, y4}, {4'hF, 4'b1011});

    // R5: output follows within one clock phase, no edge between
    @(posedge clk);
    #0.5 g8 = 3'b001; a8 = 3'd5;
    #0.5 check("R5 first", y8, 8'b1101_1111);
    a8 = 3'd6;
    #0.5 check("R5 second", y8, 8'b1011_1111);
    g8 = 3'b011;
    #0.5 check("R5 gate drop", y8, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule